// File: doc/BRIEF.md
# Virtual Screen Frame Buffer Address Generator

This block walks a rectangular viewport that sits inside a wider virtual screen held in memory. It emits word-aligned read addresses for a display controller. Software supplies a frame start address, split into a fixed upper bank field and a counting lower base field in halfword units. It also supplies the viewport width in halfwords, the number of halfwords skipped between the end of one displayed line and the start of the next, and the line count minus one. The generator fetches each line as consecutive words, jumps over the skipped region, and detects the end of the frame by comparing against a computed end address. It then pulses a frame-done flag and restarts from the start address.

Fetch requests use a valid/ready handshake. A second, independent path takes the returned read data and can swap bytes and/or halfwords. In 8-bit-per-pixel mode it can also add a palette index offset to every byte before the word is handed to the pixel pipeline.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: After reset is released and before enable is raised, fetch_valid_o, frame_done_o and pix_valid_o are 0.
- R2: fetch_addr_o is a byte address. Bits [28:22] carry the bank field latched at frame start, bits [21:2] carry the low 20 bits of the word counter, and bits [1:0] are 0. The counter wraps inside the bank, so the bank bits never change during a frame.
- R3: Each line fetches width_i[10:1] consecutive words, starting at word base_i[20:1]. Bit 0 of base_i, width_i and skip_i is ignored. width_i must be at least 2.
- R4: The first word of each line after the first lies (width_i[10:1] + skip_i[10:1]) words after the first word of the previous line.
- R5: The frame ends when the next line start equals base + (width + skip) * (lines_m1_i + 1), computed in words. frame_done_o is 1 in the cycle after the final accepted fetch, and fetch_addr_o shows the new frame's first word in that same cycle.
- R6: While fetch_valid_o is 1 and fetch_ready_i is 0, the request stays valid and fetch_addr_o does not change.
- R7: bank_i, base_i, width_i, skip_i and lines_m1_i are sampled only when a frame starts. Changes during a frame take effect at the next frame.
- R8: When enable_i is 0, fetch_valid_o is 0 from the next cycle. Raising enable_i again restarts at the frame start address.
- R9: pix_data_o and pix_valid_o follow rdata_i and rdata_valid_i one cycle later. swap_byte_i exchanges the two bytes inside each halfword. swap_half_i exchanges the two halfwords. When both are set, the byte swap is applied first.
- R10: When pix_fmt_i is 4'b1011 (8 bits per pixel) and pal_off_en_i is 1, pal_off_i is added modulo 256 to every byte after swapping. Any other code, including 4'b1100 (16 bits per pixel), adds no offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the scan |
| bank_i | input | 7 | Fixed upper address field, bits 28:22 |
| base_i | input | 21 | Frame start, halfword address bits 21:1 |
| width_i | input | 11 | Viewport width in halfwords |
| skip_i | input | 11 | Halfwords skipped between lines |
| lines_m1_i | input | 10 | Displayed lines minus one |
| fetch_ready_i | input | 1 | Memory accepts the request |
| fetch_valid_o | output | 1 | Fetch request valid |
| fetch_addr_o | output | 29 | Word-aligned fetch byte address |
| frame_done_o | output | 1 | Frame completed pulse |
| rdata_i | input | 32 | Returned read data |
| rdata_valid_i | input | 1 | Read data valid |
| swap_byte_i | input | 1 | Swap bytes inside halfwords |
| swap_half_i | input | 1 | Swap halfwords |
| pix_fmt_i | input | 4 | Pixel format code |
| pal_off_en_i | input | 1 | Palette offset enable |
| pal_off_i | input | 8 | Palette index offset |
| pix_data_o | output | 32 | Formatted data |
| pix_valid_o | output | 1 | Formatted data valid |

## Verification
The bench targets the line-to-line jump: a design that drops the skip would read the hidden part of the virtual screen. It also checks the end compare. An off-by-one end address makes the scan run one line too long or stop one line short, and a missed reload leaves the counter running into the next frame. Further cases cover a one-word frame, where frame_done_o must pulse after every fetch, and a base field that wraps at the bank boundary, where a carry into the bank bits would show as a wrong upper address. Other runs check that configuration changed mid-frame waits for the reload, and that a stalled request keeps its address. On the data side, the bench checks the swap order when both swaps are set, and byte-wise modulo-256 offset addition, which catches a carry leaking between lanes.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int unsigned BANK_W = 7;
  localparam int unsigned BASE_W = 21;
  localparam int unsigned FLD_W  = 11;
  localparam int unsigned LINE_W = 10;
  localparam int unsigned DATA_W = 32;
  localparam logic [3:0]  FMT_8BPP  = 4'b1011;
  localparam logic [3:0]  FMT_16BPP = 4'b1100;
endpackage

// File: rtl/fb_end_calc.sv
module fb_end_calc #(
  parameter int unsigned FLD_W  = 11,
  parameter int unsigned LINE_W = 10,
  parameter int unsigned CNT_W  = 23,
  localparam int unsigned WPL_W = FLD_W - 1,
  localparam int unsigned PRD_W = FLD_W + LINE_W + 1
) (
  input  logic [CNT_W-1:0]  base_w_i,
  input  logic [WPL_W-1:0]  wpl_i,
  input  logic [WPL_W-1:0]  skw_i,
  input  logic [LINE_W-1:0] lines_m1_i,
  output logic [CNT_W-1:0]  end_w_o
);
  logic [FLD_W-1:0]  stride;
  logic [LINE_W:0]   rows;
  logic [PRD_W-1:0]  span;

  always_comb begin
    stride  = {1'b0, wpl_i} + {1'b0, skw_i};
    rows    = {1'b0, lines_m1_i} + 1'b1;
    span    = PRD_W'(stride) * PRD_W'(rows);
    end_w_o = base_w_i + CNT_W'(span);
  end
endmodule

// File: rtl/fb_addr_seq.sv
module fb_addr_seq #(
  parameter int unsigned BANK_W = 7,
  parameter int unsigned BASE_W = 21,
  parameter int unsigned FLD_W  = 11,
  parameter int unsigned LINE_W = 10,
  localparam int unsigned CNT_W  = BASE_W + 2,
  localparam int unsigned WPL_W  = FLD_W - 1,
  localparam int unsigned ADDR_W = BANK_W + BASE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [FLD_W-1:0]  width_i,
  input  logic [FLD_W-1:0]  skip_i,
  input  logic [LINE_W-1:0] lines_m1_i,
  input  logic              ready_i,
  input  logic [CNT_W-1:0]  end_w_i,
  output logic [CNT_W-1:0]  base_w_o,
  output logic [WPL_W-1:0]  wpl_o,
  output logic [WPL_W-1:0]  skw_o,
  output logic [LINE_W-1:0] lines_m1_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  logic              run_q, done_q;
  logic [BANK_W-1:0] bank_q;
  logic [CNT_W-1:0]  base_q, line_q, cur_q;
  logic [WPL_W-1:0]  wpl_q, skw_q, col_q;
  logic [LINE_W-1:0] lines_q;

  logic              accept, last_col, frame_end;
  logic [CNT_W-1:0]  next_line;

  always_comb begin
    accept    = run_q & ready_i;
    last_col  = (col_q == wpl_q - 1'b1);
    next_line = line_q + CNT_W'(wpl_q) + CNT_W'(skw_q);
    frame_end = last_col & (next_line == end_w_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      bank_q  <= '0;
      base_q  <= '0;
      line_q  <= '0;
      cur_q   <= '0;
      wpl_q   <= '0;
      skw_q   <= '0;
      col_q   <= '0;
      lines_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!enable_i) begin
        run_q <= 1'b0;
      end else if (!run_q || (accept && frame_end)) begin
        // frame start: sample configuration, drop LSBs for word alignment
        run_q   <= 1'b1;
        done_q  <= run_q;
        bank_q  <= bank_i;
        base_q  <= CNT_W'(base_i[BASE_W-1:1]);
        line_q  <= CNT_W'(base_i[BASE_W-1:1]);
        cur_q   <= CNT_W'(base_i[BASE_W-1:1]);
        wpl_q   <= width_i[FLD_W-1:1];
        skw_q   <= skip_i[FLD_W-1:1];
        lines_q <= lines_m1_i;
        col_q   <= '0;
      end else if (accept) begin
        if (last_col) begin
          col_q  <= '0;
          line_q <= next_line;
          cur_q  <= next_line;
        end else begin
          col_q <= col_q + 1'b1;
          cur_q <= cur_q + 1'b1;
        end
      end
    end
  end

  assign base_w_o   = base_q;
  assign wpl_o      = wpl_q;
  assign skw_o      = skw_q;
  assign lines_m1_o = lines_q;
  assign valid_o    = run_q;
  assign done_o     = done_q;
  assign addr_o     = {bank_q, cur_q[BASE_W-2:0], 2'b00};

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && enable_i |=> valid_o && $stable(addr_o));

  p_col_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && (wpl_q != 0) |-> col_q < wpl_q);

  p_line_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && (wpl_q != 0) |-> line_q < end_w_i);

  p_done_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> run_q && (cur_q == base_q) && (col_q == '0));

  p_bank_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) && !done_q |-> $stable(bank_q));
endmodule

// File: rtl/fb_data_fmt.sv
module fb_data_fmt #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NBYTE = DATA_W / 8,
  localparam int unsigned HALF  = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              swap_byte_i,
  input  logic              swap_half_i,
  input  logic [3:0]        fmt_i,
  input  logic              off_en_i,
  input  logic [7:0]        off_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] byte_sw, half_sw, with_off;
  logic              add_off;

  assign add_off = off_en_i && (fmt_i == fb_pkg::FMT_8BPP);

  for (genvar i = 0; i < NBYTE; i += 2) begin : g_bswap
    assign byte_sw[i*8 +: 8]     = swap_byte_i ? data_i[(i+1)*8 +: 8] : data_i[i*8 +: 8];
    assign byte_sw[(i+1)*8 +: 8] = swap_byte_i ? data_i[i*8 +: 8]     : data_i[(i+1)*8 +: 8];
  end

  assign half_sw = swap_half_i ? {byte_sw[HALF-1:0], byte_sw[DATA_W-1:HALF]} : byte_sw;

  for (genvar i = 0; i < NBYTE; i++) begin : g_lane
    assign with_off[i*8 +: 8] = half_sw[i*8 +: 8] + (add_off ? off_i : 8'h00);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= with_off;
    end
  end

  p_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

// File: rtl/fb_scan_addr_gen.sv
module fb_scan_addr_gen #(
  parameter int unsigned BANK_W = fb_pkg::BANK_W,
  parameter int unsigned BASE_W = fb_pkg::BASE_W,
  parameter int unsigned FLD_W  = fb_pkg::FLD_W,
  parameter int unsigned LINE_W = fb_pkg::LINE_W,
  parameter int unsigned DATA_W = fb_pkg::DATA_W,
  localparam int unsigned CNT_W  = BASE_W + 2,
  localparam int unsigned WPL_W  = FLD_W - 1,
  localparam int unsigned ADDR_W = BANK_W + BASE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [FLD_W-1:0]  width_i,
  input  logic [FLD_W-1:0]  skip_i,
  input  logic [LINE_W-1:0] lines_m1_i,
  input  logic              fetch_ready_i,
  output logic              fetch_valid_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              frame_done_o,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rdata_valid_i,
  input  logic              swap_byte_i,
  input  logic              swap_half_i,
  input  logic [3:0]        pix_fmt_i,
  input  logic              pal_off_en_i,
  input  logic [7:0]        pal_off_i,
  output logic [DATA_W-1:0] pix_data_o,
  output logic              pix_valid_o
);
  logic [CNT_W-1:0]  base_w, end_w;
  logic [WPL_W-1:0]  wpl, skw;
  logic [LINE_W-1:0] lines_m1;

  fb_addr_seq #(.BANK_W(BANK_W), .BASE_W(BASE_W), .FLD_W(FLD_W), .LINE_W(LINE_W)) u_seq (
    .clk_i, .rst_ni, .enable_i, .bank_i, .base_i, .width_i, .skip_i, .lines_m1_i,
    .ready_i    (fetch_ready_i),
    .end_w_i    (end_w),
    .base_w_o   (base_w),
    .wpl_o      (wpl),
    .skw_o      (skw),
    .lines_m1_o (lines_m1),
    .valid_o    (fetch_valid_o),
    .addr_o     (fetch_addr_o),
    .done_o     (frame_done_o)
  );

  fb_end_calc #(.FLD_W(FLD_W), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_end (
    .base_w_i   (base_w),
    .wpl_i      (wpl),
    .skw_i      (skw),
    .lines_m1_i (lines_m1),
    .end_w_o    (end_w)
  );

  fb_data_fmt #(.DATA_W(DATA_W)) u_fmt (
    .clk_i, .rst_ni,
    .data_i      (rdata_i),
    .valid_i     (rdata_valid_i),
    .swap_byte_i,
    .swap_half_i,
    .fmt_i       (pix_fmt_i),
    .off_en_i    (pal_off_en_i),
    .off_i       (pal_off_i),
    .data_o      (pix_data_o),
    .valid_o     (pix_valid_o)
  );
endmodule

// File: tb/fb_scan_addr_gen_tb.sv
module fb_scan_addr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {din, swap_byte, swap_half, fmt, off_en, off, expected}
  localparam logic [78:0] VEC [NVEC] = '{
    {32'h11223344, 1'b0, 1'b0, 4'b1100, 1'b1, 8'h10, 32'h11223344},
    {32'h11223344, 1'b1, 1'b0, 4'b1100, 1'b0, 8'h00, 32'h22114433},
    {32'h11223344, 1'b0, 1'b1, 4'b1100, 1'b0, 8'h00, 32'h33441122},
    {32'h11223344, 1'b1, 1'b1, 4'b1100, 1'b0, 8'h00, 32'h44332211},
    {32'h11223344, 1'b0, 1'b0, 4'b1011, 1'b1, 8'h01, 32'h12233445},
    {32'h11223344, 1'b0, 1'b0, 4'b1011, 1'b0, 8'h01, 32'h11223344},
    {32'hFF800001, 1'b0, 1'b0, 4'b1011, 1'b1, 8'h80, 32'h7F008081},
    {32'h11223344, 1'b1, 1'b1, 4'b1011, 1'b1, 8'h10, 32'h54433221}
  };

  logic        clk_i = 0, rst_ni = 0, enable_i = 0;
  logic [6:0]  bank_i = 0;
  logic [20:0] base_i = 0;
  logic [10:0] width_i = 0, skip_i = 0;
  logic [9:0]  lines_m1_i = 0;
  logic        fetch_ready_i = 0, fetch_valid_o, frame_done_o;
  logic [28:0] fetch_addr_o;
  logic [31:0] rdata_i = 0, pix_data_o;
  logic        rdata_valid_i = 0, swap_byte_i = 0, swap_half_i = 0;
  logic [3:0]  pix_fmt_i = 0;
  logic        pal_off_en_i = 0, pix_valid_o;
  logic [7:0]  pal_off_i = 0;

  int checks = 0, errors = 0;
  bit sw_en = 0;
  logic [6:0] nb_bank; logic [20:0] nb_base; logic [10:0] nb_w, nb_s; logic [9:0] nb_l;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fb_scan_addr_gen u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [28:0] exp_addr(input logic [6:0] bank, input int word);
    return {bank, 20'(word), 2'b00};
  endfunction

  task automatic set_cfg(input logic [6:0] b, input logic [20:0] a, input logic [10:0] w,
                         input logic [10:0] s, input logic [9:0] l);
    bank_i = b; base_i = a; width_i = w; skip_i = s; lines_m1_i = l;
  endtask

  // called at a negedge with the frame's first word showing; ends at the negedge after the last accept
  task automatic walk_frame(input logic [6:0] b, input logic [20:0] a, input logic [10:0] w,
                            input logic [10:0] s, input logic [9:0] l, input string req);
    int bw = int'(a) >> 1, wpl = int'(w) >> 1, skw = int'(s) >> 1, k = 0;
    for (int ln = 0; ln <= int'(l); ln++) begin
      for (int c = 0; c < wpl; c++) begin
        int word = bw + ln * (wpl + skw) + c;
        chk(fetch_valid_o === 1'b1, req, 32'(fetch_valid_o), 32'd1);
        chk(fetch_addr_o === exp_addr(b, word), req, 32'(fetch_addr_o), 32'(exp_addr(b, word)));
        if (k > 0) chk(frame_done_o === 1'b0, "R5 no early done", 32'(frame_done_o), 0);
        if (k == 1 && sw_en) begin
          set_cfg(nb_bank, nb_base, nb_w, nb_s, nb_l);
          sw_en = 0;
        end
        k++;
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(fetch_valid_o === 1'b0, "R1 valid", 32'(fetch_valid_o), 0);
    chk(frame_done_o === 1'b0, "R1 done", 32'(frame_done_o), 0);
    chk(pix_valid_o === 1'b0, "R1 pix_valid", 32'(pix_valid_o), 0);

    // data formatting table: R9 swaps, R10 palette offset
    for (int i = 0; i < NVEC; i++) begin
      {rdata_i, swap_byte_i, swap_half_i, pix_fmt_i, pal_off_en_i, pal_off_i} = VEC[i][78:32];
      rdata_valid_i = 1;
      @(negedge clk_i);
      chk(pix_valid_o === 1'b1, "R9 latency", 32'(pix_valid_o), 1);
      chk(pix_data_o === VEC[i][31:0], (i >= 4) ? "R10 offset" : "R9 swap", pix_data_o, VEC[i][31:0]);
    end
    rdata_valid_i = 0;
    @(negedge clk_i);
    chk(pix_valid_o === 1'b0, "R9 valid drop", 32'(pix_valid_o), 0);

    // frame 1: R3 R4 with mid-frame config change (R7)
    set_cfg(7'h05, 21'h000100, 11'd4, 11'd6, 10'd2);
    nb_bank = 7'h7F; nb_base = 21'h000201; nb_w = 11'd3; nb_s = 11'd1; nb_l = 10'd0;
    sw_en = 1;
    fetch_ready_i = 1;
    enable_i = 1;
    @(negedge clk_i);
    walk_frame(7'h05, 21'h000100, 11'd4, 11'd6, 10'd2, "R4 line skip");
    chk(frame_done_o === 1'b1, "R5 done pulse", 32'(frame_done_o), 1);
    chk(fetch_addr_o === exp_addr(7'h7F, 'h100), "R7 new cfg at reload", 32'(fetch_addr_o), 32'(exp_addr(7'h7F, 'h100)));

    // one-word frame, odd LSBs ignored (R3)
    walk_frame(7'h7F, 21'h000201, 11'd3, 11'd1, 10'd0, "R3 lsb ignored");
    chk(frame_done_o === 1'b1, "R5 single word done", 32'(frame_done_o), 1);
    set_cfg(7'h2A, 21'h1FFFFE, 11'd4, 11'd0, 10'd0);
    @(negedge clk_i);
    chk(frame_done_o === 1'b1, "R5 done again", 32'(frame_done_o), 1);

    // bank wrap (R2)
    walk_frame(7'h2A, 21'h1FFFFE, 11'd4, 11'd0, 10'd0, "R2 bank wrap");
    chk(frame_done_o === 1'b1, "R5 wrap frame done", 32'(frame_done_o), 1);
    chk(fetch_addr_o[28:22] === 7'h2A, "R2 bank bits", 32'(fetch_addr_o[28:22]), 32'h2A);

    // stall (R6)
    fetch_ready_i = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(fetch_valid_o === 1'b1, "R6 valid held", 32'(fetch_valid_o), 1);
      chk(fetch_addr_o === exp_addr(7'h2A, 'hFFFFF), "R6 addr held", 32'(fetch_addr_o), 32'(exp_addr(7'h2A, 'hFFFFF)));
      chk(frame_done_o === 1'b0, "R6 no done in stall", 32'(frame_done_o), 0);
    end
    fetch_ready_i = 1;
    @(negedge clk_i);
    chk(fetch_addr_o === exp_addr(7'h2A, 'h100000), "R6 resume", 32'(fetch_addr_o), 32'(exp_addr(7'h2A, 'h100000)));

    // enable drop mid-frame (R8)
    enable_i = 0;
    @(negedge clk_i);
    chk(fetch_valid_o === 1'b0, "R8 valid off", 32'(fetch_valid_o), 0);
    @(negedge clk_i);
    chk(fetch_valid_o === 1'b0, "R8 stays off", 32'(fetch_valid_o), 0);
    enable_i = 1;
    @(negedge clk_i);
    walk_frame(7'h2A, 21'h1FFFFE, 11'd4, 11'd0, 10'd0, "R8 restart at base");
    chk(frame_done_o === 1'b1, "R5 done after restart", 32'(frame_done_o), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule